// File: doc/BRIEF.md
# Pointer-Stepping Store and Branch Execute Unit

This execute-stage unit serves a small extension to a 32-bit load/store instruction set. It carries out four store forms that write a byte or a full word at the address held in a pointer register. Each of these stores then moves the pointer up or down by the access size. It also carries out two loop-closing branches. Each branch compares a pointer register with a limit register, moves the pointer by a power-of-two step, and redirects fetch when the two values differed.

The decoder supplies the operation code, the pointer, data and limit register values, a step exponent, a signed branch offset and the instruction address. One clock edge after issue, the unit presents its results together: a memory write request (address, data and byte enables), a write-back of the updated pointer, and a taken flag with its target. The pointer arithmetic runs beside the store or the compare, so the write-back costs no extra cycle. Compares and memory addresses use the pointer value from before the update. Fetch, decode, the register file and hazard handling belong to the surrounding core.

Top module: `ptrstep_exu`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the strobes mem_we, wb_en, br_taken and misalign are all low, and mem_addr, wb_val and br_target read zero.
- R2: Operation code 3'b001 (byte store, step up) writes to mem_addr = pointer. mem_be has the single bit k set, where k is pointer[1:0]. mem_wdata repeats the data register's bits 7:0 in all four lanes. wb_val = pointer + 1.
- R3: Operation code 3'b010 (byte store, step down) drives the same address, lane and data as R2. wb_val = pointer - 1, wrapping modulo 2^32.
- R4: Operation codes 3'b011 (word store, step up) and 3'b100 (word store, step down) write the full data register at mem_addr = pointer with mem_be = 4'b1111. Lane k carries data bits 8k+7:8k. wb_val = pointer + 4 or pointer - 4.
- R5: A word store whose pointer has bits 1:0 non-zero raises misalign for one cycle. It raises neither mem_we nor wb_en.
- R6: Operation code 3'b101 (branch, step up) gives wb_val = pointer + (1 << step_exp), with step_exp from 0 to 31, modulo 2^32. br_taken is high exactly when the pointer before the update differs from the limit. br_target = pc + the sign-extended 13-bit offset.
- R7: Operation code 3'b110 (branch, step down) behaves as R6, except that wb_val = pointer - (1 << step_exp).
- R8: All results of an operation issued with op_valid high at a rising edge appear together in the cycle after that edge. wb_en is high for every store that is carried out and for every branch. In a cycle after an edge without op_valid, all strobes are low.
- R9: Operation codes 3'b000 and 3'b111 are ignored: even with op_valid high, no strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is issued this cycle |
| op_code | input | 3 | Operation selector |
| pc | input | 32 | Address of the issued instruction |
| ptr_val | input | 32 | Pointer register value |
| data_val | input | 32 | Data register value for stores |
| lim_val | input | 32 | Limit register value for branches |
| step_exp | input | 5 | Branch step exponent n (step is 1 << n) |
| br_off | input | 13 | Signed branch offset |
| mem_we | output | 1 | Memory write request |
| mem_addr | output | 32 | Memory write address |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Memory byte enables |
| wb_en | output | 1 | Pointer write-back enable |
| wb_val | output | 32 | Updated pointer value |
| br_taken | output | 1 | Branch redirect request |
| br_target | output | 32 | Branch target address |
| misalign | output | 1 | Word store to a misaligned pointer was suppressed |

## Verification
The hardest behaviour to reach from the ports is the arithmetic at its edges. This covers pointer wrap in both directions and branch steps at the top exponent. It also covers the equal-compare case, in which the updated pointer must still be written back even though the branch is not taken. The vector table places pointers at 0, at all ones and exactly at the limit for these cases. A chained sequence then feeds each written-back pointer into the next store, and checks the memory model byte by byte, so that lane selection and step size are exposed together.

// File: rtl/ptrstep_exu.sv
module ptrstep_exu #(
  parameter int XLEN  = 32,
  parameter int OFF_W = 13,
  parameter int SHW   = $clog2(XLEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [XLEN-1:0]   pc,
  input  logic [XLEN-1:0]   ptr_val,
  input  logic [XLEN-1:0]   data_val,
  input  logic [XLEN-1:0]   lim_val,
  input  logic [SHW-1:0]    step_exp,
  input  logic [OFF_W-1:0]  br_off,
  output logic              mem_we,
  output logic [XLEN-1:0]   mem_addr,
  output logic [XLEN-1:0]   mem_wdata,
  output logic [XLEN/8-1:0] mem_be,
  output logic              wb_en,
  output logic [XLEN-1:0]   wb_val,
  output logic              br_taken,
  output logic [XLEN-1:0]   br_target,
  output logic              misalign
);
  localparam int LANES = XLEN / 8;
  localparam int LSB   = $clog2(LANES);

  localparam logic [2:0] OP_SB_UP = 3'b001;
  localparam logic [2:0] OP_SB_DN = 3'b010;
  localparam logic [2:0] OP_SW_UP = 3'b011;
  localparam logic [2:0] OP_SW_DN = 3'b100;
  localparam logic [2:0] OP_BR_UP = 3'b101;
  localparam logic [2:0] OP_BR_DN = 3'b110;

  logic is_sb, is_sw, is_br, is_dn, bad_al, do_st, do_wb;
  logic [XLEN-1:0]  step, nxt_ptr, tgt, rep_data;
  logic [LANES-1:0] lane_be;

  assign is_sb  = (op_code == OP_SB_UP) || (op_code == OP_SB_DN);
  assign is_sw  = (op_code == OP_SW_UP) || (op_code == OP_SW_DN);
  assign is_br  = (op_code == OP_BR_UP) || (op_code == OP_BR_DN);
  assign is_dn  = (op_code == OP_SB_DN) || (op_code == OP_SW_DN) || (op_code == OP_BR_DN);
  assign bad_al = is_sw && (ptr_val[LSB-1:0] != '0);
  assign do_st  = is_sb || (is_sw && !bad_al);
  assign do_wb  = do_st || is_br;

  assign step    = is_br ? (XLEN'(1) << step_exp) : (is_sw ? XLEN'(LANES) : XLEN'(1));
  assign nxt_ptr = is_dn ? (ptr_val - step) : (ptr_val + step);
  assign tgt     = pc + {{(XLEN-OFF_W){br_off[OFF_W-1]}}, br_off};
  assign lane_be = is_sw ? '1 : (LANES'(1) << ptr_val[LSB-1:0]);
  assign rep_data = is_sw ? data_val : {LANES{data_val[7:0]}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_we    <= 1'b0;
      wb_en     <= 1'b0;
      br_taken  <= 1'b0;
      misalign  <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_be    <= '0;
      wb_val    <= '0;
      br_target <= '0;
    end else begin
      mem_we   <= op_valid && do_st;
      wb_en    <= op_valid && do_wb;
      br_taken <= op_valid && is_br && (ptr_val != lim_val);
      misalign <= op_valid && bad_al;
      if (op_valid) begin
        mem_addr  <= ptr_val;
        mem_wdata <= rep_data;
        mem_be    <= lane_be;
        wb_val    <= nxt_ptr;
        br_target <= tgt;
      end
    end
  end
endmodule

// File: rtl/ptrstep_exu_chk.sv
module ptrstep_exu_chk #(
  parameter int XLEN = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic              mem_we,
  input logic [XLEN-1:0]   mem_addr,
  input logic [XLEN-1:0]   mem_wdata,
  input logic [XLEN/8-1:0] mem_be,
  input logic              wb_en,
  input logic [XLEN-1:0]   wb_val,
  input logic              br_taken,
  input logic              misalign
);
  localparam int LANES = XLEN / 8;
  localparam int LSB   = $clog2(LANES);

  assert_byte_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_be != '1) |-> (mem_be == (LANES'(1) << mem_addr[LSB-1:0])));

  assert_byte_copy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_be != '1) |-> (mem_wdata == {LANES{mem_wdata[7:0]}}));

  assert_byte_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_be != '1) |-> (wb_val == mem_addr + XLEN'(1) || wb_val == mem_addr - XLEN'(1)));

  assert_word_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_be == '1) |-> (mem_addr[LSB-1:0] == '0 &&
      (wb_val == mem_addr + XLEN'(LANES) || wb_val == mem_addr - XLEN'(LANES))));

  assert_misalign_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (!mem_we && !wb_en && !br_taken));

  assert_taken_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> (wb_en && !mem_we));

  assert_store_wb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> wb_en);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(op_valid) |-> (!mem_we && !wb_en && !br_taken && !misalign));
endmodule

bind ptrstep_exu ptrstep_exu_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
  .wb_en(wb_en), .wb_val(wb_val), .br_taken(br_taken), .misalign(misalign)
);

// File: tb/ptrstep_exu_tb.sv
`timescale 1ns/1ps
module ptrstep_exu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = '0;
  logic [31:0] pc = '0, ptr_val = '0, data_val = '0, lim_val = '0;
  logic [4:0]  step_exp = '0;
  logic [12:0] br_off = '0;
  logic        mem_we, wb_en, br_taken, misalign;
  logic [31:0] mem_addr, mem_wdata, wb_val, br_target;
  logic [3:0]  mem_be;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  ptrstep_exu u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .pc(pc),
    .ptr_val(ptr_val), .data_val(data_val), .lim_val(lim_val), .step_exp(step_exp),
    .br_off(br_off), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .wb_en(wb_en), .wb_val(wb_val), .br_taken(br_taken),
    .br_target(br_target), .misalign(misalign)
  );

  logic [7:0] mem [0:63];
  always @(posedge clk)
    if (mem_we)
      for (int l = 0; l < 4; l++)
        if (mem_be[l]) mem[{mem_addr[5:2], l[1:0]}] <= mem_wdata[8*l +: 8];

  localparam int NV = 10;
  localparam logic [2:0]  V_OP  [NV] = '{3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd5, 3'd6, 3'd6, 3'd1, 3'd5};
  localparam logic [31:0] V_PTR [NV] = '{32'h1000_0002, 32'h1000_0000, 32'h2000_0010, 32'h2000_0010,
                                         32'h3000_0000, 32'h3000_0040, 32'h0000_0010, 32'h0,
                                         32'hFFFF_FFFF, 32'h0};
  localparam logic [31:0] V_DAT [NV] = '{32'h1234_56AB, 32'h0000_00CD, 32'hDEAD_BEEF, 32'hCAFE_F00D,
                                         32'h0, 32'h0, 32'h0, 32'h0, 32'h7777_7715, 32'h0};
  localparam logic [31:0] V_LIM [NV] = '{32'h0, 32'h0, 32'h0, 32'h0, 32'h3000_0040, 32'h3000_0040,
                                         32'h0, 32'h0, 32'h0, 32'h1};
  localparam logic [4:0]  V_SH  [NV] = '{5'd0, 5'd0, 5'd0, 5'd0, 5'd3, 5'd2, 5'd4, 5'd0, 5'd0, 5'd31};
  localparam logic [12:0] V_OFF [NV] = '{13'h0, 13'h0, 13'h0, 13'h0, 13'h1FF0, 13'h0040, 13'h0100,
                                         13'h1000, 13'h0, 13'h0FFF};
  localparam logic [31:0] V_PC  [NV] = '{32'h0, 32'h0, 32'h0, 32'h0, 32'h400, 32'h400, 32'h800,
                                         32'h2000, 32'h0, 32'h0};
  localparam logic [31:0] V_WB  [NV] = '{32'h1000_0003, 32'h0FFF_FFFF, 32'h2000_0014, 32'h2000_000C,
                                         32'h3000_0008, 32'h3000_0044, 32'h0000_0000, 32'hFFFF_FFFF,
                                         32'h0000_0000, 32'h8000_0000};

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(logic [2:0] op, logic [31:0] p, logic [31:0] d, logic [31:0] lm,
                       logic [4:0] sh, logic [12:0] off, logic [31:0] ipc);
    @(negedge clk);
    op_valid = 1'b1; op_code = op; ptr_val = p; data_val = d; lim_val = lm;
    step_exp = sh; br_off = off; pc = ipc;
    @(negedge clk);
    op_valid = 1'b0; op_code = '0;
  endtask

  task automatic check_vec(int i);
    logic [2:0] op = V_OP[i];
    logic       st = (op == 3'd1 || op == 3'd2 || op == 3'd3 || op == 3'd4);
    logic       br = (op == 3'd5 || op == 3'd6);
    logic       wd = (op == 3'd3 || op == 3'd4);
    string      rq;
    rq = (op == 3'd1) ? "R2" : (op == 3'd2) ? "R3" : wd ? "R4" : (op == 3'd5) ? "R6" : "R7";
    chk($sformatf("%s vec%0d wb_val", rq, i), wb_val, V_WB[i]);
    chk($sformatf("R8 vec%0d wb_en", i), {31'b0, wb_en}, 32'd1);
    chk($sformatf("%s vec%0d mem_we", rq, i), {31'b0, mem_we}, {31'b0, st});
    if (st) begin
      chk($sformatf("%s vec%0d addr", rq, i), mem_addr, V_PTR[i]);
      chk($sformatf("%s vec%0d be", rq, i), {28'b0, mem_be},
          wd ? 32'hF : (32'd1 << V_PTR[i][1:0]));
      chk($sformatf("%s vec%0d data", rq, i), mem_wdata,
          wd ? V_DAT[i] : {4{V_DAT[i][7:0]}});
    end
    if (br) begin
      chk($sformatf("%s vec%0d taken", rq, i), {31'b0, br_taken}, {31'b0, V_PTR[i] != V_LIM[i]});
      chk($sformatf("%s vec%0d target", rq, i), br_target,
          V_PC[i] + {{19{V_OFF[i][12]}}, V_OFF[i]});
    end else
      chk($sformatf("%s vec%0d no branch", rq, i), {31'b0, br_taken}, 32'd0);
    chk($sformatf("R5 vec%0d misalign", i), {31'b0, misalign}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  %0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    for (int a = 0; a < 64; a++) mem[a] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 reset strobes", {28'b0, mem_we, wb_en, br_taken, misalign}, 32'd0);
    chk("R1 reset wb_val", wb_val, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset strobes", {28'b0, mem_we, wb_en, br_taken, misalign}, 32'd0);
    chk("R1 after reset addr/target", mem_addr | br_target, 32'd0);

    for (int i = 0; i < NV; i++) begin
      issue(V_OP[i], V_PTR[i], V_DAT[i], V_LIM[i], V_SH[i], V_OFF[i], V_PC[i]);
      check_vec(i);
    end

    // R8: the cycle after an operation, with no new issue, is quiet
    @(negedge clk);
    chk("R8 idle strobes", {28'b0, mem_we, wb_en, br_taken, misalign}, 32'd0);

    // R5: misaligned word stores, both directions
    issue(3'd3, 32'h0000_0101, 32'h1111_1111, 0, 0, 0, 0);
    chk("R5 misalign up flag", {31'b0, misalign}, 32'd1);
    chk("R5 misalign up no store/wb", {30'b0, mem_we, wb_en}, 32'd0);
    issue(3'd4, 32'h0000_0103, 32'h1111_1111, 0, 0, 0, 0);
    chk("R5 misalign down flag", {31'b0, misalign}, 32'd1);
    chk("R5 misalign down no store/wb", {30'b0, mem_we, wb_en}, 32'd0);
    issue(3'd4, 32'h0000_0002, 32'h1111_1111, 0, 0, 0, 0);
    chk("R5 misalign half offset", {29'b0, misalign, mem_we, wb_en}, 32'd4);

    // R9: reserved codes do nothing
    issue(3'd0, 32'h40, 32'hFF, 32'h0, 5'd1, 13'h10, 32'h100);
    chk("R9 code 000 strobes", {28'b0, mem_we, wb_en, br_taken, misalign}, 32'd0);
    issue(3'd7, 32'h41, 32'hFF, 32'h0, 5'd1, 13'h10, 32'h100);
    chk("R9 code 111 strobes", {28'b0, mem_we, wb_en, br_taken, misalign}, 32'd0);

    // R2/R4: chained pointer, contents checked in the memory model
    begin
      logic [31:0] p = 32'h20;
      logic [7:0]  b [3] = '{8'h11, 8'h22, 8'h33};
      for (int k = 0; k < 3; k++) begin
        issue(3'd1, p, {24'hABCDEF, b[k]}, 0, 0, 0, 0);
        p = wb_val;
      end
      chk("R2 chained pointer", p, 32'h23);
      p = 32'h28;
      issue(3'd3, p, 32'hA1B2_C3D4, 0, 0, 0, 0);
      chk("R4 word wb", wb_val, 32'h2C);
      issue(3'd2, 32'h23, 32'h0000_0044, 0, 0, 0, 0);
      chk("R3 byte down wb", wb_val, 32'h22);
      @(negedge clk);
      chk("R2 mem bytes 20..23", {mem[32'h23], mem[32'h22], mem[32'h21], mem[32'h20]}, 32'h4433_2211);
      chk("R4 mem word 28", {mem[32'h2B], mem[32'h2A], mem[32'h29], mem[32'h28]}, 32'hA1B2_C3D4);
    end

    // R8: back-to-back issues each appear one cycle later
    @(negedge clk);
    op_valid = 1'b1; op_code = 3'd5; ptr_val = 32'h5; lim_val = 32'h5; step_exp = 5'd1;
    br_off = 13'h8; pc = 32'h10;
    @(negedge clk);
    chk("R8 b2b first wb", wb_val, 32'h7);
    chk("R6 equal not taken", {30'b0, br_taken, wb_en}, 32'd1);
    op_code = 3'd6; ptr_val = 32'h9; lim_val = 32'h5; step_exp = 5'd2;
    @(negedge clk);
    op_valid = 1'b0;
    chk("R7 b2b second wb", wb_val, 32'h5);
    chk("R7 b2b taken", {31'b0, br_taken}, 32'd1);
    chk("R7 target", br_target, 32'h18);

    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 re-reset strobes", {28'b0, mem_we, wb_en, br_taken, misalign}, 32'd0);

    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule